// File: doc/BRIEF.md
# Fixed-Frequency Flyback PWM Modulator

This block produces the gate-drive enable for the main switch of an off-line flyback converter. A free-running counter plays the part of the oscillator sawtooth. Each switching period has two parts. In the first part the ramp rises, and the switch is held off. In the second part the ramp falls from its peak towards its valley, and the switch may conduct. The default period is 500 cycles, which gives 100 kHz from a 50 MHz clock. The default split is 140 rising cycles and 360 falling cycles, which caps the duty cycle at 72 %.

An internal set/reset state bit is set only at the ramp peak. It is cleared in either of two cases:
- The falling ramp crosses the 10-bit feedback code.
- The overcurrent flag is seen after a blanking window measured from turn-on.

Because of this, the block gives at most one pulse per period. An overcurrent event ends the pulse early, and the pulse cannot restart before the next peak.

The protection sequencer drives a global enable. When the enable is low, the gate is forced off. The gate output is registered, and a synchronous active-high reset clears it.

Top module: `flyback_pwm_mod`

## Requirements
- R1: While reset is high, and after reset until the first ramp peak, `gate_drv` is 0. The first turn-on happens no earlier than CHARGE_CYC cycles after reset is released.
- R2: Successive rising edges of `gate_drv` are exactly PERIOD cycles apart when the on-time is held constant (500 cycles by default).
- R3: In every period `gate_drv` is low for at least CHARGE_CYC cycles. The longest possible pulse is PERIOD−CHARGE_CYC cycles (360 of 500 by default, a 72 % duty ceiling).
- R4: For VALLEY_CODE < fb_code < PEAK_CODE, the pulse lasts ceil((PEAK_CODE−fb_code)·(PERIOD−CHARGE_CYC)/(PEAK_CODE−VALLEY_CODE)) cycles. With the defaults (200, 840), code 520 gives 180 cycles and code 832 gives 5 cycles.
- R5: A code at or below VALLEY_CODE gives the maximum pulse of PERIOD−CHARGE_CYC cycles.
- R6: A code at or above PEAK_CODE gives no pulse at all in that period.
- R7: `gate_drv` rises only in the cycle after a ramp peak. There is at most one rising edge per period, even while `oc_flag` is held high.
- R8: If `oc_flag` is high in a cycle where the gate has already been high for at least BLANK_CYC cycles, the gate is low in the next cycle. It stays low until the next peak. BLANK_CYC defaults to 8, so a held flag gives a pulse of BLANK_CYC+1 = 9 cycles.
- R9: `oc_flag` is ignored during the first BLANK_CYC cycles of each pulse. In those cycles the pulse ends only through the feedback comparison.
- R10: `run_en` low forces `gate_drv` low in the next cycle and clears the state bit. After `run_en` returns high, the first pulse starts at the next peak and has the full on-time set by the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Global enable from the protection sequencer |
| fb_code | input | FB_W | Digitised feedback level (higher means less duty) |
| oc_flag | input | 1 | Overcurrent indication from current sensing |
| gate_drv | output | 1 | Registered gate-drive enable |

## Verification
Two things can end a pulse in the same cycle: the feedback comparator and an overcurrent flag that the blanking window has just released. The bench sets up this case in two ways while holding the flag high.
- It picks code 824, whose comparator end falls exactly on the cycle the blanking window ends. The expected pulse is 9 cycles.
- It picks code 832, whose comparator end falls inside the blanking window. The expected pulse is 5 cycles.

In both cases the bench checks for one clean pulse per period and no second turn-on. To do this it counts high samples, rising edges and the longest run over three whole periods.

// File: rtl/flyback_pwm_pkg.sv
package flyback_pwm_pkg;
  typedef enum logic {PH_RISE = 1'b0, PH_FALL = 1'b1} ramp_phase_t;

  function automatic int on_cycles(input int code, input int valley, input int peak, input int fall_len);
    int c;
    c = (code < valley) ? valley : ((code > peak) ? peak : code);
    return ((peak - c) * fall_len + (peak - valley) - 1) / (peak - valley);
  endfunction
endpackage

// File: rtl/fpm_ramp_gen.sv
module fpm_ramp_gen
  import flyback_pwm_pkg::*;
#(
  parameter int PERIOD     = 500,
  parameter int CHARGE_CYC = 140,
  parameter int KW         = 9
) (
  input  logic          clk,
  input  logic          rst,
  output ramp_phase_t   phase,
  output logic          peak,
  output logic [KW-1:0] fall_idx
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt;
  logic [CW-1:0] since_peak;

  always_ff @(posedge clk) begin
    if (rst)                            cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))    cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  assign since_peak = cnt - CW'(CHARGE_CYC);
  assign phase      = (cnt < CW'(CHARGE_CYC)) ? PH_RISE : PH_FALL;
  assign fall_idx   = KW'(since_peak);
  assign peak       = (cnt == CW'(CHARGE_CYC));
endmodule

// File: rtl/fpm_duty_cmp.sv
module fpm_duty_cmp #(
  parameter int FB_W        = 10,
  parameter int VALLEY_CODE = 200,
  parameter int PEAK_CODE   = 840,
  parameter int FALL_LEN    = 360,
  parameter int KW          = 9
) (
  input  logic [FB_W-1:0] fb_code,
  input  logic [KW-1:0]   fall_idx,
  output logic            cmp_end
);
  localparam int SPAN = PEAK_CODE - VALLEY_CODE;
  localparam int MW   = FB_W + KW + 2;

  logic [FB_W-1:0] fb_clamp;
  logic [MW-1:0]   ramp_drop;
  logic [MW-1:0]   fb_margin;

  always_comb begin
    if (fb_code < FB_W'(VALLEY_CODE))     fb_clamp = FB_W'(VALLEY_CODE);
    else if (fb_code > FB_W'(PEAK_CODE))  fb_clamp = FB_W'(PEAK_CODE);
    else                                  fb_clamp = fb_code;
  end

  // ramp has fallen below feedback once drop*FALL_LEN reaches margin (scaled)
  assign ramp_drop = MW'(SPAN) * MW'(fall_idx);
  assign fb_margin = (MW'(PEAK_CODE) - MW'(fb_clamp)) * MW'(FALL_LEN);
  assign cmp_end   = (ramp_drop >= fb_margin);
endmodule

// File: rtl/fpm_blank_timer.sv
module fpm_blank_timer #(
  parameter int BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic oc_flag,
  output logic oc_valid
);
  localparam int AW = $clog2(BLANK_CYC + 2);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst || !gate)              age <= '0;
    else if (age != AW'(BLANK_CYC)) age <= age + 1'b1;
  end

  assign oc_valid = gate && oc_flag && (age == AW'(BLANK_CYC));
endmodule

// File: rtl/flyback_pwm_mod.sv
module flyback_pwm_mod
  import flyback_pwm_pkg::*;
#(
  parameter int FB_W        = 10,
  parameter int PERIOD      = 500,
  parameter int CHARGE_CYC  = 140,
  parameter int VALLEY_CODE = 200,
  parameter int PEAK_CODE   = 840,
  parameter int BLANK_CYC   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic [FB_W-1:0] fb_code,
  input  logic            oc_flag,
  output logic            gate_drv
);
  localparam int FALL_LEN = PERIOD - CHARGE_CYC;
  localparam int KW       = $clog2(FALL_LEN + 1);

  ramp_phase_t   phase;
  logic          peak_evt;
  logic          in_charge;
  logic [KW-1:0] fall_idx;
  logic          cmp_end;
  logic          oc_valid;
  logic          gate_q;
  logic          gate_nxt;

  fpm_ramp_gen #(.PERIOD(PERIOD), .CHARGE_CYC(CHARGE_CYC), .KW(KW)) u_ramp (
    .clk(clk), .rst(rst), .phase(phase), .peak(peak_evt), .fall_idx(fall_idx)
  );

  fpm_duty_cmp #(.FB_W(FB_W), .VALLEY_CODE(VALLEY_CODE), .PEAK_CODE(PEAK_CODE),
                 .FALL_LEN(FALL_LEN), .KW(KW)) u_cmp (
    .fb_code(fb_code), .fall_idx(fall_idx), .cmp_end(cmp_end)
  );

  fpm_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .gate(gate_q), .oc_flag(oc_flag), .oc_valid(oc_valid)
  );

  assign in_charge = (phase == PH_RISE);

  // set at peak only; reset by comparator, released overcurrent or disable
  always_comb begin
    gate_nxt = 1'b0;
    if (run_en && !in_charge && (peak_evt || gate_q))
      gate_nxt = !cmp_end && !oc_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_nxt;
  end

  assign gate_drv = gate_q;
endmodule

// File: rtl/flyback_pwm_mod_chk.sv
module flyback_pwm_mod_chk #(
  parameter int PERIOD    = 500,
  parameter int BLANK_CYC = 8
) (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic oc_flag,
  input logic gate_drv,
  input logic peak_evt,
  input logic in_charge,
  input logic cmp_end
);
  int   hi_run;
  int   gap;
  logic seen_peak;

  always_ff @(posedge clk) begin
    if (rst || !gate_drv)        hi_run <= 0;
    else if (hi_run < BLANK_CYC) hi_run <= hi_run + 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= 0;
      seen_peak <= 1'b0;
    end else if (peak_evt) begin
      gap <= 0;
      seen_peak <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !gate_drv);
  a_r2_peak_spacing: assert property (@(posedge clk) disable iff (rst)
    (peak_evt && seen_peak) |-> (gap == PERIOD - 1));
  a_r3_off_while_rising: assert property (@(posedge clk) disable iff (rst)
    in_charge |=> !gate_drv);
  a_r7_rise_after_peak: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_drv) |-> $past(peak_evt));
  a_r8_oc_ends_pulse: assert property (@(posedge clk) disable iff (rst)
    (gate_drv && oc_flag && hi_run >= BLANK_CYC) |=> !gate_drv);
  a_r9_oc_blanked: assert property (@(posedge clk) disable iff (rst)
    (gate_drv && hi_run < BLANK_CYC && run_en && !in_charge && !cmp_end) |=> gate_drv);
  a_r10_disable_off: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !gate_drv);
endmodule

bind flyback_pwm_mod flyback_pwm_mod_chk #(.PERIOD(PERIOD), .BLANK_CYC(BLANK_CYC)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .oc_flag(oc_flag), .gate_drv(gate_drv),
  .peak_evt(peak_evt), .in_charge(in_charge), .cmp_end(cmp_end)
);

// File: tb/flyback_pwm_mod_tb.sv
module flyback_pwm_mod_tb;
  localparam int FB_W    = 10;
  localparam int PERIOD  = 500;
  localparam int CHARGE  = 140;
  localparam int FALL    = PERIOD - CHARGE;
  localparam int VALLEY  = 200;
  localparam int PEAKC   = 840;
  localparam int BLANK   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            run_en = 1'b1;
  logic [FB_W-1:0] fb_code = 10'd520;
  logic            oc_flag = 1'b0;
  logic            gate_drv;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  flyback_pwm_mod #(.FB_W(FB_W), .PERIOD(PERIOD), .CHARGE_CYC(CHARGE),
                    .VALLEY_CODE(VALLEY), .PEAK_CODE(PEAKC), .BLANK_CYC(BLANK)) u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .fb_code(fb_code),
    .oc_flag(oc_flag), .gate_drv(gate_drv)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic int exp_on(input int code);
    int c;
    c = (code < VALLEY) ? VALLEY : ((code > PEAKC) ? PEAKC : code);
    return ((PEAKC - c) * FALL + (PEAKC - VALLEY) - 1) / (PEAKC - VALLEY);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // three whole periods: high samples, rising edges, longest run
  task automatic measure(output int highs, output int rises, output int maxrun);
    logic prev;
    int run;
    @(negedge clk);
    prev = gate_drv;
    highs = 0; rises = 0; maxrun = 0; run = 0;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      if (gate_drv) begin
        highs++; run++;
        if (run > maxrun) maxrun = run;
        if (!prev) rises++;
      end else run = 0;
      prev = gate_drv;
    end
  endtask

  task automatic wait_rise(output bit found);
    logic prev;
    @(negedge clk);
    prev = gate_drv;
    found = 1'b0;
    for (int i = 0; i < 2 * PERIOD && !found; i++) begin
      @(negedge clk);
      if (gate_drv && !prev) found = 1'b1;
      prev = gate_drv;
    end
  endtask

  task automatic t_reset;
    bit all_low = 1'b1;
    rst = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (gate_drv !== 1'b0) all_low = 1'b0;
    end
    check(all_low, "R1 low during reset", gate_drv, 0);
    rst = 1'b0;
    for (int i = 0; i < CHARGE; i++) begin
      @(negedge clk);
      if (gate_drv !== 1'b0) all_low = 1'b0;
    end
    check(all_low, "R1 low before first peak", gate_drv, 0);
  endtask

  task automatic t_period;
    bit f;
    int n;
    logic prev;
    fb_code = 10'd520;
    wait_rise(f);
    n = 0; prev = 1'b1;
    for (int i = 0; i < 2 * PERIOD; i++) begin
      @(negedge clk);
      n++;
      if (gate_drv && !prev) break;
      prev = gate_drv;
    end
    check(f && n == PERIOD, "R2 rise-to-rise spacing", n, PERIOD);
  endtask

  task automatic t_duty(input int code, input string tag);
    int h, r, m, e;
    fb_code = FB_W'(code);
    repeat (2 * PERIOD) @(negedge clk);
    measure(h, r, m);
    e = exp_on(code);
    check(h == 3 * e, {tag, " on-cycles over 3 periods"}, h, 3 * e);
    check(r == ((e > 0) ? 3 : 0), {tag, " R7 one rise per period"}, r, (e > 0) ? 3 : 0);
    check(m == e, {tag, " pulse width"}, m, e);
  endtask

  task automatic t_oc_hold(input int code, input string tag);
    int h, r, m, e;
    fb_code = FB_W'(code);
    oc_flag = 1'b1;
    repeat (PERIOD) @(negedge clk);
    measure(h, r, m);
    e = exp_on(code);
    if (e > BLANK + 1) e = BLANK + 1;
    check(m == e, {tag, " pulse with flag held"}, m, e);
    check(r == 3, {tag, " R7 no second turn-on"}, r, 3);
    check(h == 3 * e, {tag, " stays off to next peak"}, h, 3 * e);
    oc_flag = 1'b0;
  endtask

  task automatic t_oc_blanked;
    bit f;
    int run;
    fb_code = 10'd520;
    repeat (PERIOD) @(negedge clk);
    wait_rise(f);
    run = 1;
    oc_flag = 1'b1;
    for (int i = 0; i < BLANK; i++) begin
      @(negedge clk);
      if (gate_drv) run++;
    end
    oc_flag = 1'b0;
    while (gate_drv && run < PERIOD) begin
      @(negedge clk);
      if (gate_drv) run++;
    end
    check(f && run == exp_on(520), "R9 flag in blanking ignored", run, exp_on(520));
  endtask

  task automatic t_oc_late;
    bit f;
    int run;
    wait_rise(f);
    run = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (gate_drv) run++;
    end
    oc_flag = 1'b1;
    @(negedge clk);
    oc_flag = 1'b0;
    if (gate_drv) run++;
    while (gate_drv && run < PERIOD) begin
      @(negedge clk);
      if (gate_drv) run++;
    end
    check(f && run == 13, "R8 flag after blanking ends pulse", run, 13);
  endtask

  task automatic t_enable;
    bit f;
    bit all_low = 1'b1;
    int run;
    fb_code = 10'd520;
    wait_rise(f);
    repeat (20) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    check(gate_drv == 1'b0, "R10 off next cycle", gate_drv, 0);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      @(negedge clk);
      if (gate_drv) all_low = 1'b0;
    end
    check(all_low, "R10 off while disabled", gate_drv, 0);
    repeat (CHARGE + 100) @(negedge clk);
    run_en = 1'b1;
    wait_rise(f);
    run = 1;
    while (gate_drv && run < PERIOD) begin
      @(negedge clk);
      if (gate_drv) run++;
    end
    check(f && run == exp_on(520), "R10 first pulse full length", run, exp_on(520));
  endtask

  initial begin
    t_reset();
    t_period();
    t_duty(520, "R4 code520");
    t_duty(832, "R4 code832");
    t_duty(700, "R4 code700");
    t_duty(0, "R5 R3 code0");
    t_duty(200, "R5 code200");
    t_duty(840, "R6 code840");
    t_duty(1023, "R6 code1023");
    t_oc_hold(0, "R8 full duty");
    t_oc_hold(824, "R8 coincident end");
    t_oc_hold(832, "R9 comparator inside blank");
    t_oc_blanked();
    t_oc_late();
    t_enable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule